// File: doc/BRIEF.md
# Fault Debounce and Restart Supervisor

This block sits between the digitized protection comparators of an offline flyback controller and its gate driver. It watches supply over-voltage, sampled output over- and under-voltage, line brownout, over-temperature, current-sense short and diode short. Each condition is filtered, either by a count of clock ticks or by a count of switching cycles marked by a per-cycle strobe. Once a condition is confirmed, the block stops switching and steps the supply through a restart sequence.

Two restart forms exist. The plain form stops gating and waits for the supply to decay to the HV re-enable level, then recharges from the high-voltage start-up path. The extended form is used for output under-voltage. It lets the supply swing between the HV re-enable and turn-on levels for a set number of charge cycles, in low-current mode, before it tries again. Every start attempt opens a brown-in window after the turn-on level is reached. Switching starts only if the brown-in flag is seen inside that window.

Top module: `fault_restart_sup`

## Requirements
- R1: After reset the gate is inhibited, the HV start-up path is enabled, the low-current flag is clear, and the block waits for the turn-on flag.
- R2: When the turn-on flag is seen, a window of BIN_TICKS clocks opens. The first clock inside it with the brown-in flag high releases the gate on the next clock. While the gate is released, the HV start-up path is disabled.
- R3: If the brown-in flag stays low for the whole window, the block enters plain auto-restart with the gate still inhibited and HV disabled.
- R4: While switching, a supply over-voltage flag high for VOVP_TICKS consecutive clocks enters plain auto-restart. A shorter run has no effect.
- R5: A sampled output over-voltage flag high at OOV_CYC consecutive strobes (3 by default) enters plain auto-restart.
- R6: A line-sense flag low for BO_TICKS consecutive clocks (brownout) enters plain auto-restart.
- R7: The over-temperature flag enters plain auto-restart on the first clock it is seen while switching.
- R8: A diode-short flag at a single strobe enters plain auto-restart. A current-sense short must be present at CS_CYC consecutive strobes (2 by default).
- R9: Each debounce count restarts from zero when its condition is absent: on any clock for the time-based filters, and at any strobe for the cycle-based filters.
- R10: An output under-voltage flag at UVP_CYC consecutive strobes (2 by default) enters extended restart. During the first UVP_BLANK_TICKS clocks of each switching run it is ignored.
- R11: In plain auto-restart the turn-off flag sets the low-current flag. The HV re-enable flag clears the fault, enables HV start-up and returns to waiting for turn-on. The turn-on flag then opens a new brown-in window and clears the low-current flag.
- R12: Extended restart sets the low-current flag at once, with HV disabled. The HV re-enable flag turns HV on and the turn-on flag turns it off again, which completes one charge cycle. After EXT_CYCLES such cycles a brown-in window opens and the low-current flag clears.
- R13: When a plain-restart cause and an extended-restart cause are confirmed in the same clock, plain auto-restart is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdd_ovp_i | input | 1 | Supply over-voltage comparator |
| out_ovp_i | input | 1 | Sampled output over-voltage, valid at strobe |
| out_uvp_i | input | 1 | Sampled output under-voltage, valid at strobe |
| line_ok_i | input | 1 | Line-sense current above brownout level |
| otp_i | input | 1 | Over-temperature |
| cs_short_i | input | 1 | Current-sense short, valid at strobe |
| diode_short_i | input | 1 | Diode short, valid at strobe |
| vdd_on_i | input | 1 | Supply reached turn-on level |
| vdd_off_i | input | 1 | Supply fell to turn-off level |
| vdd_hv_i | input | 1 | Supply fell to HV re-enable level |
| brownin_i | input | 1 | Brown-in condition detected |
| cyc_stb_i | input | 1 | One pulse per switching cycle |
| gate_inh_o | output | 1 | Gate drive inhibited |
| hv_en_o | output | 1 | HV start-up path enabled |
| lowi_o | output | 1 | Low operating current mode |

## Verification
The bench shrinks the time windows to VOVP_TICKS=5, BO_TICKS=8, UVP_BLANK_TICKS=20 and BIN_TICKS=6. It keeps the cycle counts at their defaults: 3, 2, 2, 1 and 2 extended cycles. With these values every filter can be driven to one short of its limit and then to its limit within a few dozen clocks. The under-voltage blanking can be hit both inside and after its window, and both restart flavours, including the two-cycle swing, run to completion several times in one short run.

// File: rtl/fault_restart_sup.sv
module fault_restart_sup #(
  parameter int VOVP_TICKS      = 700,
  parameter int BO_TICKS        = 165000,
  parameter int UVP_BLANK_TICKS = 450000,
  parameter int BIN_TICKS       = 1000,
  parameter int OOV_CYC         = 3,
  parameter int UVP_CYC         = 2,
  parameter int CS_CYC          = 2,
  parameter int DS_CYC          = 1,
  parameter int EXT_CYCLES      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vdd_ovp_i,
  input  logic out_ovp_i,
  input  logic out_uvp_i,
  input  logic line_ok_i,
  input  logic otp_i,
  input  logic cs_short_i,
  input  logic diode_short_i,
  input  logic vdd_on_i,
  input  logic vdd_off_i,
  input  logic vdd_hv_i,
  input  logic brownin_i,
  input  logic cyc_stb_i,
  output logic gate_inh_o,
  output logic hv_en_o,
  output logic lowi_o
);

  localparam int VW    = $clog2(VOVP_TICKS + 1);
  localparam int BW    = $clog2(BO_TICKS + 1);
  localparam int KW    = $clog2(UVP_BLANK_TICKS + 1);
  localparam int NW    = $clog2(BIN_TICKS + 1);
  localparam int EW    = $clog2(EXT_CYCLES + 1);
  localparam int M1    = (OOV_CYC > UVP_CYC) ? OOV_CYC : UVP_CYC;
  localparam int M2    = (CS_CYC > DS_CYC) ? CS_CYC : DS_CYC;
  localparam int CYMAX = (M1 > M2) ? M1 : M2;
  localparam int CYW   = $clog2(CYMAX + 1);

  localparam logic [VW-1:0]  VOVP_LAST  = VW'(VOVP_TICKS - 1);
  localparam logic [BW-1:0]  BO_LAST    = BW'(BO_TICKS - 1);
  localparam logic [KW-1:0]  BLANK_FULL = KW'(UVP_BLANK_TICKS);
  localparam logic [NW-1:0]  BIN_LAST   = NW'(BIN_TICKS - 1);
  localparam logic [EW-1:0]  EXT_LAST   = EW'(EXT_CYCLES - 1);
  localparam logic [CYW-1:0] OOV_LAST   = CYW'(OOV_CYC - 1);
  localparam logic [CYW-1:0] UVP_LAST   = CYW'(UVP_CYC - 1);
  localparam logic [CYW-1:0] CS_LAST    = CYW'(CS_CYC - 1);
  localparam logic [CYW-1:0] DS_LAST    = CYW'(DS_CYC - 1);

  typedef enum logic [2:0] {S_WAIT, S_BIN, S_RUN, S_AR, S_EXT} st_t;
  st_t st;

  logic [VW-1:0]  c_vovp;
  logic [BW-1:0]  c_bo;
  logic [KW-1:0]  blank;
  logic [NW-1:0]  win;
  logic [EW-1:0]  ext_n;
  logic [CYW-1:0] c_oov, c_uvp, c_cs, c_ds;
  logic           chg, lowi_q;

  logic run, blank_done;
  logic t_vovp, t_bo, t_oov, t_uvp, t_cs, t_ds, plain, ext;

  assign run        = (st == S_RUN);
  assign blank_done = (blank == BLANK_FULL);

  assign t_vovp = vdd_ovp_i && (c_vovp == VOVP_LAST);
  assign t_bo   = !line_ok_i && (c_bo == BO_LAST);
  assign t_oov  = cyc_stb_i && out_ovp_i && (c_oov == OOV_LAST);
  assign t_cs   = cyc_stb_i && cs_short_i && (c_cs == CS_LAST);
  assign t_ds   = cyc_stb_i && diode_short_i && (c_ds == DS_LAST);
  assign t_uvp  = cyc_stb_i && out_uvp_i && blank_done && (c_uvp == UVP_LAST);
  assign plain  = t_vovp || t_bo || otp_i || t_oov || t_cs || t_ds;
  assign ext    = t_uvp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !run) begin
      c_vovp <= '0;
      c_bo   <= '0;
      blank  <= '0;
      c_oov  <= '0;
      c_uvp  <= '0;
      c_cs   <= '0;
      c_ds   <= '0;
    end else begin
      c_vovp <= vdd_ovp_i ? c_vovp + 1'b1 : '0;
      c_bo   <= !line_ok_i ? c_bo + 1'b1 : '0;
      if (!blank_done) blank <= blank + 1'b1;
      if (cyc_stb_i) begin
        c_oov <= out_ovp_i ? c_oov + 1'b1 : '0;
        c_cs  <= cs_short_i ? c_cs + 1'b1 : '0;
        c_ds  <= diode_short_i ? c_ds + 1'b1 : '0;
        c_uvp <= (out_uvp_i && blank_done) ? c_uvp + 1'b1 : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_WAIT;
      win    <= '0;
      ext_n  <= '0;
      chg    <= 1'b0;
      lowi_q <= 1'b0;
    end else begin
      unique case (st)
        S_WAIT: if (vdd_on_i) begin
          st     <= S_BIN;
          win    <= '0;
          lowi_q <= 1'b0;
        end
        S_BIN: begin
          if (brownin_i)            st  <= S_RUN;
          else if (win == BIN_LAST) st  <= S_AR;
          else                      win <= win + 1'b1;
        end
        S_RUN: begin
          if (plain) st <= S_AR;
          else if (ext) begin
            st     <= S_EXT;
            lowi_q <= 1'b1;
            chg    <= 1'b0;
            ext_n  <= '0;
          end
        end
        S_AR: begin
          if (vdd_off_i) lowi_q <= 1'b1;
          if (vdd_hv_i)  st     <= S_WAIT;
        end
        S_EXT: begin
          if (!chg) begin
            if (vdd_hv_i) chg <= 1'b1;
          end else if (vdd_on_i) begin
            chg <= 1'b0;
            if (ext_n == EXT_LAST) begin
              st     <= S_BIN;
              win    <= '0;
              lowi_q <= 1'b0;
            end else begin
              ext_n <= ext_n + 1'b1;
            end
          end
        end
        default: st <= S_WAIT;
      endcase
    end
  end

  assign gate_inh_o = !run;
  assign hv_en_o    = (st == S_WAIT) || (st == S_BIN) || ((st == S_EXT) && chg);
  assign lowi_o     = lowi_q;

  // R2
  hv_gate_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hv_en_o && !gate_inh_o));

  // R2
  release_needs_brownin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_inh_o) |-> $past(brownin_i));

  // R7
  otp_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && otp_i) |=> (gate_inh_o && st == S_AR));

  // R8
  diode_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cyc_stb_i && diode_short_i) |=> gate_inh_o);

  // R9
  vovp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vdd_ovp_i |=> (c_vovp == '0));

  // R11
  lowi_on_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_AR && vdd_off_i) |=> lowi_o);

  // R12
  ext_charge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hv_en_o) && st == S_EXT) |-> $past(vdd_hv_i));

  // R13
  plain_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && plain && ext) |=> (st == S_AR));

endmodule

// File: tb/sim_fault_restart_sup.sv
module sim_fault_restart_sup;
  localparam int P_VOVP = 5, P_BO = 8, P_BLANK = 20, P_BIN = 6;
  localparam int P_OOV = 3, P_UVP = 2, P_CS = 2, P_DS = 1, P_EXT = 2;

  logic clk = 0, rst_n = 0;
  logic vdd_ovp = 0, out_ovp = 0, out_uvp = 0, line_ok = 1, otp = 0;
  logic cs_short = 0, diode_short = 0, vdd_on = 0, vdd_off = 0, vdd_hv = 0;
  logic brownin = 1, stb = 0;
  logic gate_inh, hv_en, lowi;

  always #5 clk = ~clk;

  fault_restart_sup #(
    .VOVP_TICKS(P_VOVP), .BO_TICKS(P_BO), .UVP_BLANK_TICKS(P_BLANK), .BIN_TICKS(P_BIN),
    .OOV_CYC(P_OOV), .UVP_CYC(P_UVP), .CS_CYC(P_CS), .DS_CYC(P_DS), .EXT_CYCLES(P_EXT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .vdd_ovp_i(vdd_ovp), .out_ovp_i(out_ovp), .out_uvp_i(out_uvp),
    .line_ok_i(line_ok), .otp_i(otp), .cs_short_i(cs_short), .diode_short_i(diode_short),
    .vdd_on_i(vdd_on), .vdd_off_i(vdd_off), .vdd_hv_i(vdd_hv), .brownin_i(brownin),
    .cyc_stb_i(stb), .gate_inh_o(gate_inh), .hv_en_o(hv_en), .lowi_o(lowi)
  );

  // behavioural reference: 0 wait, 1 window, 2 switching, 3 restart, 4 extended
  int ms, n_ov, n_bo, n_bl, n_oo, n_uv, n_cs, n_ds, n_win, n_ext;
  bit m_chg, m_low;
  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; n_ov = 0; n_bo = 0; n_bl = 0; n_oo = 0; n_uv = 0; n_cs = 0; n_ds = 0;
      n_win = 0; n_ext = 0; m_chg = 0; m_low = 0;
    end else begin
      int nxt;
      bit pl, ex;
      nxt = ms;
      if (ms == 2) begin
        pl = otp || (vdd_ovp && n_ov + 1 >= P_VOVP) || (!line_ok && n_bo + 1 >= P_BO);
        ex = 0;
        if (stb) begin
          pl = pl || (out_ovp && n_oo + 1 >= P_OOV) || (cs_short && n_cs + 1 >= P_CS)
                  || (diode_short && n_ds + 1 >= P_DS);
          ex = out_uvp && n_bl >= P_BLANK && n_uv + 1 >= P_UVP;
        end
        n_ov = vdd_ovp ? n_ov + 1 : 0;
        n_bo = !line_ok ? n_bo + 1 : 0;
        if (stb) begin
          n_oo = out_ovp ? n_oo + 1 : 0;
          n_cs = cs_short ? n_cs + 1 : 0;
          n_ds = diode_short ? n_ds + 1 : 0;
          n_uv = (out_uvp && n_bl >= P_BLANK) ? n_uv + 1 : 0;
        end
        if (n_bl < P_BLANK) n_bl++;
        if (pl) nxt = 3;
        else if (ex) begin nxt = 4; m_low = 1; m_chg = 0; n_ext = 0; end
      end else if (ms == 0) begin
        if (vdd_on) begin nxt = 1; n_win = 0; m_low = 0; end
      end else if (ms == 1) begin
        if (brownin) nxt = 2;
        else if (n_win == P_BIN - 1) nxt = 3;
        else n_win++;
      end else if (ms == 3) begin
        if (vdd_off) m_low = 1;
        if (vdd_hv) nxt = 0;
      end else begin
        if (!m_chg) begin
          if (vdd_hv) m_chg = 1;
        end else if (vdd_on) begin
          m_chg = 0;
          n_ext++;
          if (n_ext == P_EXT) begin nxt = 1; n_win = 0; m_low = 0; end
        end
      end
      if (nxt != 2) begin
        n_ov = 0; n_bo = 0; n_bl = 0; n_oo = 0; n_uv = 0; n_cs = 0; n_ds = 0;
      end
      ms = nxt;
    end
  end

  task automatic compare();
    bit eg, eh;
    eg = (ms != 2);
    eh = (ms == 0) || (ms == 1) || (ms == 4 && m_chg);
    checks++;
    if (gate_inh !== eg || hv_en !== eh || lowi !== m_low) begin
      fails++;
      $display("FAIL %s t=%0t gate/hv/low actual=%b%b%b expected=%b%b%b",
               cur_req, $time, gate_inh, hv_en, lowi, eg, eh, m_low);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      compare();
    end
  endtask

  task automatic expect_out(input string r, input bit g, input bit h, input bit l);
    checks++;
    if (gate_inh !== g || hv_en !== h || lowi !== l) begin
      fails++;
      $display("FAIL %s gate/hv/low actual=%b%b%b expected=%b%b%b", r, gate_inh, hv_en, lowi, g, h, l);
    end
  endtask

  task automatic boot();
    vdd_on = 1; cyc(1); vdd_on = 0; cyc(2);
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      stb = 1; cyc(1); stb = 0; cyc(2);
    end
  endtask

  task automatic recover();
    vdd_off = 1; cyc(1); vdd_off = 0; cyc(2);
    vdd_hv = 1; cyc(1); vdd_hv = 0; cyc(1);
    boot();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    cur_req = "R1";
    expect_out("R1", 1, 1, 0);
    rst_n = 1;
    cyc(4);
    expect_out("R1", 1, 1, 0);

    cur_req = "R2";
    boot();
    expect_out("R2", 0, 0, 0);
    cyc(3);

    cur_req = "R4";
    vdd_ovp = 1; cyc(P_VOVP - 1); vdd_ovp = 0; cyc(1);
    expect_out("R4", 0, 0, 0);
    cur_req = "R9";
    vdd_ovp = 1; cyc(P_VOVP - 1); vdd_ovp = 0; cyc(1);
    expect_out("R9", 0, 0, 0);
    cur_req = "R4";
    vdd_ovp = 1; cyc(P_VOVP); vdd_ovp = 0;
    expect_out("R4", 1, 0, 0);

    cur_req = "R11";
    vdd_off = 1; cyc(1); vdd_off = 0;
    expect_out("R11", 1, 0, 1);
    cyc(2);
    vdd_hv = 1; cyc(1); vdd_hv = 0;
    expect_out("R11", 1, 1, 1);
    cyc(2);
    vdd_on = 1; cyc(1); vdd_on = 0;
    expect_out("R11", 1, 1, 0);
    cyc(2);

    cur_req = "R5";
    out_ovp = 1; strobe(P_OOV - 1); out_ovp = 0; strobe(1);
    expect_out("R5", 0, 0, 0);
    out_ovp = 1; strobe(P_OOV); out_ovp = 0;
    expect_out("R5", 1, 0, 0);
    recover();

    cur_req = "R6";
    line_ok = 0; cyc(P_BO - 1); line_ok = 1; cyc(1);
    expect_out("R6", 0, 0, 0);
    line_ok = 0; cyc(P_BO); line_ok = 1;
    expect_out("R6", 1, 0, 0);
    recover();

    cur_req = "R7";
    otp = 1; cyc(1); otp = 0;
    expect_out("R7", 1, 0, 0);
    recover();

    cur_req = "R8";
    diode_short = 1; strobe(1); diode_short = 0;
    expect_out("R8", 1, 0, 0);
    recover();
    cs_short = 1; strobe(1); cs_short = 0; strobe(1);
    expect_out("R8", 0, 0, 0);
    cs_short = 1; strobe(P_CS); cs_short = 0;
    expect_out("R8", 1, 0, 0);
    recover();

    cur_req = "R10";
    out_uvp = 1; strobe(3); out_uvp = 0;
    expect_out("R10", 0, 0, 0);
    cyc(P_BLANK);
    out_uvp = 1; strobe(1); out_uvp = 0; strobe(1);
    expect_out("R10", 0, 0, 0);
    out_uvp = 1; strobe(P_UVP); out_uvp = 0;
    expect_out("R10", 1, 0, 1);

    cur_req = "R12";
    cyc(2);
    for (int k = 0; k < P_EXT; k++) begin
      vdd_hv = 1; cyc(1); vdd_hv = 0;
      expect_out("R12", 1, 1, 1);
      cyc(2);
      vdd_on = 1; cyc(1); vdd_on = 0;
      if (k < P_EXT - 1) expect_out("R12", 1, 0, 1);
      else expect_out("R12", 1, 1, 0);
      cyc(1);
    end
    cyc(1);
    expect_out("R12", 0, 0, 0);

    cur_req = "R13";
    cyc(P_BLANK);
    out_uvp = 1; strobe(1);
    otp = 1; stb = 1; cyc(1); stb = 0; otp = 0; out_uvp = 0;
    expect_out("R13", 1, 0, 0);
    cyc(2);
    recover();

    cur_req = "R3";
    vdd_off = 1; otp = 1; cyc(1); otp = 0; vdd_off = 0;
    vdd_hv = 1; cyc(1); vdd_hv = 0;
    brownin = 0;
    vdd_on = 1; cyc(1); vdd_on = 0;
    cyc(P_BIN - 1);
    expect_out("R3", 1, 1, 0);
    cyc(1);
    expect_out("R3", 1, 0, 0);
    brownin = 1;
    cyc(3);
    expect_out("R3", 1, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=hung expected=completed");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule